// File: doc/BRIEF.md
# General-Purpose Pin Port with Function Multiplexer

This block controls a port of general-purpose pins. Each pin has an output latch and a direction bit of its own. A per-pin function code decides what drives the pad: the port's own latch and direction, or the output and output-enable of one of several peripherals. Software reaches the port over a small register bus. That bus can load the output latch directly, or change individual latch bits with set, clear and toggle writes.

Reads of the data word return the levels at the pins, not the latch contents. The pin levels arrive already qualified. The block copies these levels to the input of every peripheral all the time, whatever function the pins are assigned to. A peripheral can therefore watch a pin that software is driving, or a pin that another function owns.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every latch bit, every direction bit and every function code is zero. As a result `pad_oe` and `pad_out` are all zero.
- R2: A pin with function code 0 drives `pad_out` from its latch bit and `pad_oe` from its direction bit.
- R3: Function codes 1, 2 and 3 connect peripheral 1, 2 and 3 to the pin. Peripheral k (k = 1..3) supplies its output on bits `[(k-1)*32 + i]` of `periph_out` and its enable on the same bits of `periph_oe`.
- R4: The function code for pin i (i < 16) is held in bits [2i+1:2i] of word 5. The code for pin 16+i is held in bits [2i+1:2i] of word 6. Both words read back as written.
- R5: A write to word 0 loads the output latch. A read of word 0 returns `pad_in` as it was in the cycle of the read.
- R6: Writes to word 1 (set), word 2 (clear) and word 3 (toggle) change only the latch bits written as 1. Set drives those bits to 1, clear drives them to 0 and toggle inverts them. All other bits are unchanged.
- R7: Word 4 holds the direction bits: 1 makes the pin an output, 0 an input. An input pin in function 0 has `pad_oe` low and keeps its latch value, which appears on the pad once the pin becomes an output. Word 4 reads back as written.
- R8: For every peripheral, `periph_in` equals `pad_in`, whatever the function codes are.
- R9: A read takes one cycle. `bus_rdata` is valid in the cycle after `bus_rd_en` and keeps its value until the next read.
- R10: Reads of words 1, 2, 3 and 7 return zero. A read and a write to the same word in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| pad_in | input | 32 | Qualified pin levels |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |
| periph_out | input | 96 | Outputs of peripherals 1..3, 32 bits each |
| periph_oe | input | 96 | Output enables of peripherals 1..3 |
| periph_in | output | 96 | Pin levels copied to each peripheral |

## Verification
Two pairs of operations can land in the same clock edge. The first is a read of the data word while the pin levels change: the bench changes `pad_in` in the same half-cycle that it raises the read strobe. It then expects the new level, and expects a later level change to leave the returned word untouched. The second is a read and a write to the same register in one cycle. The bench issues both together and expects the old value on the bus, then the new value on a following read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Word addresses of the register bus
    typedef enum logic [2:0] {
        ADR_DATA    = 3'd0,
        ADR_SET     = 3'd1,
        ADR_CLR     = 3'd2,
        ADR_TGL     = 3'd3,
        ADR_DIR     = 3'd4,
        ADR_FSEL_LO = 3'd5,
        ADR_FSEL_HI = 3'd6,
        ADR_SPARE   = 3'd7
    } reg_addr_e;

    localparam int ADDR_W = 3;

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int SEL_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_PINS-1:0]       wdata,
    input  logic [NUM_PINS-1:0]       pad_in,
    output logic [NUM_PINS-1:0]       rdata,
    output logic [NUM_PINS-1:0]       latch,
    output logic [NUM_PINS-1:0]       dir,
    output logic [NUM_PINS*SEL_W-1:0] fsel
);

    localparam int FSEL_W = NUM_PINS * SEL_W;
    localparam int HALF_W = FSEL_W / 2;

    typedef struct packed {
        logic [NUM_PINS-1:0] latch;
        logic [NUM_PINS-1:0] dir;
        logic [FSEL_W-1:0]   fsel;
        logic [NUM_PINS-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;
    reg_addr_e adr;

    assign adr = reg_addr_e'(addr);

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            unique case (adr)
                ADR_DATA:    st_d.rdata = pad_in;
                ADR_DIR:     st_d.rdata = st_q.dir;
                ADR_FSEL_LO: st_d.rdata = NUM_PINS'(st_q.fsel[HALF_W-1:0]);
                ADR_FSEL_HI: st_d.rdata = NUM_PINS'(st_q.fsel[FSEL_W-1:HALF_W]);
                default:     st_d.rdata = '0;
            endcase
        end
        if (wr_en) begin
            unique case (adr)
                ADR_DATA:    st_d.latch = wdata;
                ADR_SET:     st_d.latch = st_q.latch | wdata;
                ADR_CLR:     st_d.latch = st_q.latch & ~wdata;
                ADR_TGL:     st_d.latch = st_q.latch ^ wdata;
                ADR_DIR:     st_d.dir   = wdata;
                ADR_FSEL_LO: st_d.fsel[HALF_W-1:0]      = HALF_W'(wdata);
                ADR_FSEL_HI: st_d.fsel[FSEL_W-1:HALF_W] = HALF_W'(wdata);
                default:     st_d = st_d;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign latch = st_q.latch;
    assign dir   = st_q.dir;
    assign fsel  = st_q.fsel;

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int NUM_PINS   = 32,
    parameter int NUM_PERIPH = 3,
    parameter int SEL_W      = 2
) (
    input  logic [NUM_PINS-1:0]            latch,
    input  logic [NUM_PINS-1:0]            dir,
    input  logic [NUM_PINS*SEL_W-1:0]      fsel,
    input  logic [NUM_PERIPH*NUM_PINS-1:0] periph_out,
    input  logic [NUM_PERIPH*NUM_PINS-1:0] periph_oe,
    output logic [NUM_PINS-1:0]            pad_out,
    output logic [NUM_PINS-1:0]            pad_oe
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic [SEL_W-1:0] sel;
        assign sel = fsel[i*SEL_W +: SEL_W];

        always_comb begin
            pad_out[i] = latch[i];
            pad_oe[i]  = dir[i];
            for (int k = 1; k <= NUM_PERIPH; k++) begin
                if (sel == SEL_W'(k)) begin
                    pad_out[i] = periph_out[(k-1)*NUM_PINS + i];
                    pad_oe[i]  = periph_oe[(k-1)*NUM_PINS + i];
                end
            end
        end
    end

endmodule

// File: rtl/gpio_in_fanout.sv
module gpio_in_fanout #(
    parameter int NUM_PINS   = 32,
    parameter int NUM_PERIPH = 3
) (
    input  logic [NUM_PINS-1:0]            pad_in,
    output logic [NUM_PERIPH*NUM_PINS-1:0] periph_in
);

    for (genvar k = 0; k < NUM_PERIPH; k++) begin : g_periph
        assign periph_in[k*NUM_PINS +: NUM_PINS] = pad_in;
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    parameter int NUM_PERIPH = 3,
    localparam int SEL_W     = $clog2(NUM_PERIPH + 1),
    localparam int PW        = NUM_PERIPH * NUM_PINS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_en,
    input  logic                 bus_rd_en,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_PINS-1:0]  bus_wdata,
    output logic [NUM_PINS-1:0]  bus_rdata,
    input  logic [NUM_PINS-1:0]  pad_in,
    output logic [NUM_PINS-1:0]  pad_out,
    output logic [NUM_PINS-1:0]  pad_oe,
    input  logic [PW-1:0]        periph_out,
    input  logic [PW-1:0]        periph_oe,
    output logic [PW-1:0]        periph_in
);

    logic [NUM_PINS-1:0]       latch_w;
    logic [NUM_PINS-1:0]       dir_w;
    logic [NUM_PINS*SEL_W-1:0] fsel_w;

    gpio_regfile #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr_en),
        .rd_en (bus_rd_en),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .pad_in(pad_in),
        .rdata (bus_rdata),
        .latch (latch_w),
        .dir   (dir_w),
        .fsel  (fsel_w)
    );

    gpio_pin_mux #(.NUM_PINS(NUM_PINS), .NUM_PERIPH(NUM_PERIPH), .SEL_W(SEL_W)) u_mux (
        .latch     (latch_w),
        .dir       (dir_w),
        .fsel      (fsel_w),
        .periph_out(periph_out),
        .periph_oe (periph_oe),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    gpio_in_fanout #(.NUM_PINS(NUM_PINS), .NUM_PERIPH(NUM_PERIPH)) u_fan (
        .pad_in   (pad_in),
        .periph_in(periph_in)
    );

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int NUM_PINS = 32,
    parameter int FSEL_W   = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr_en,
    input logic                bus_rd_en,
    input logic [2:0]          bus_addr,
    input logic [NUM_PINS-1:0] bus_wdata,
    input logic [NUM_PINS-1:0] bus_rdata,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] latch,
    input logic [NUM_PINS-1:0] dir,
    input logic [FSEL_W-1:0]   fsel
);

    // R1: leaving reset, no pad is driven
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0));

    // R5: a read of the data word captures the pin levels of that cycle
    a_r5_read_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == 3'd0) |=> (bus_rdata == $past(pad_in)));

    // R9: read data holds between reads
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rdata));

    // R6: set leaves all written ones at one
    a_r6_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == 3'd1) |=> ((latch & $past(bus_wdata)) == $past(bus_wdata)));

    // R6: clear leaves all written ones at zero
    a_r6_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == 3'd2) |=> ((latch & $past(bus_wdata)) == '0));

    // R6: toggle inverts only the written ones
    a_r6_tgl_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == 3'd3) |=> (latch == ($past(latch) ^ $past(bus_wdata))));

    // R7: all pins in function 0 as inputs means no enable
    a_r7_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel == '0 && dir == '0) |-> (pad_oe == '0));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NUM_PINS(NUM_PINS), .FSEL_W(NUM_PINS*SEL_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr_en(bus_wr_en),
    .bus_rd_en(bus_rd_en),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_oe   (pad_oe),
    .latch    (latch_w),
    .dir      (dir_w),
    .fsel     (fsel_w)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [95:0] periph_out = '0;
    logic [95:0] periph_oe = '0;
    logic [95:0] periph_in;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .periph_out(periph_out), .periph_oe(periph_oe), .periph_in(periph_in)
    );

    // bench model of the writable state
    logic [31:0] m_latch = '0;
    logic [31:0] m_dir = '0;
    logic [63:0] m_fsel = '0;

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [63:0] exp_pads();
        logic [31:0] o, e;
        for (int i = 0; i < 32; i++) begin
            case (m_fsel[2*i +: 2])
                2'd0: begin o[i] = m_latch[i]; e[i] = m_dir[i]; end
                2'd1: begin o[i] = periph_out[i]; e[i] = periph_oe[i]; end
                2'd2: begin o[i] = periph_out[32+i]; e[i] = periph_oe[32+i]; end
                default: begin o[i] = periph_out[64+i]; e[i] = periph_oe[64+i]; end
            endcase
        end
        return {e, o};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 pad_oe", 96'(pad_oe), 96'h0);
        chk("R1 pad_out", 96'(pad_out), 96'h0);
        rd(3'd4, v); chk("R1 dir", 96'(v), 96'h0);
        rd(3'd5, v); chk("R1 fsel lo", 96'(v), 96'h0);
    endtask

    task automatic t_gpio_drive();
        wr(3'd4, 32'hFFFF_FFFF); m_dir = 32'hFFFF_FFFF;
        wr(3'd0, 32'hA5C3_0F96); m_latch = 32'hA5C3_0F96;
        chk("R2 pad_out", 96'(pad_out), 96'hA5C3_0F96);
        chk("R2 pad_oe", 96'(pad_oe), 96'hFFFF_FFFF);
    endtask

    task automatic t_bit_ops();
        wr(3'd0, 32'h0000_FFFF);
        wr(3'd1, 32'hF000_0000);
        chk("R6 set", 96'(pad_out), 96'hF000_FFFF);
        wr(3'd2, 32'h0000_000F);
        chk("R6 clear", 96'(pad_out), 96'hF000_FFF0);
        wr(3'd3, 32'hFF00_00FF);
        chk("R6 toggle", 96'(pad_out), 96'h0F00_FF0F);
        m_latch = 32'h0F00_FF0F;
    endtask

    task automatic t_dir_hold();
        wr(3'd4, 32'h0); m_dir = '0;
        chk("R7 input no oe", 96'(pad_oe), 96'h0);
        wr(3'd0, 32'h1234_5678); m_latch = 32'h1234_5678;
        wr(3'd4, 32'hFFFF_0000); m_dir = 32'hFFFF_0000;
        chk("R7 latch held", 96'(pad_out), 96'h1234_5678);
        chk("R7 oe mix", 96'(pad_oe), 96'hFFFF_0000);
    endtask

    task automatic t_fsel();
        logic [31:0] v;
        logic [63:0] e;
        periph_out = {32'hFFFF_0000, 32'hF0F0_F0F0, 32'hAAAA_AAAA};
        periph_oe  = {32'h00FF_00FF, 32'h3333_3333, 32'h5555_5555};
        // pin0=1, pin1=2, pin2=3, pin15=3 ; pin16=1, pin17=2, pin31=3
        wr(3'd5, 32'hC000_0039); m_fsel[31:0]  = 32'hC000_0039;
        wr(3'd6, 32'hC000_0009); m_fsel[63:32] = 32'hC000_0009;
        e = exp_pads();
        chk("R3 pad_out", 96'(pad_out), 96'(e[31:0]));
        chk("R3 pad_oe", 96'(pad_oe), 96'(e[63:32]));
        chk("R4 pin2 from p3", 96'(pad_out[2]), 96'(periph_out[66]));
        chk("R4 pin17 oe p2", 96'(pad_oe[17]), 96'(periph_oe[49]));
        rd(3'd5, v); chk("R4 lo readback", 96'(v), 96'hC000_0039);
        rd(3'd6, v); chk("R4 hi readback", 96'(v), 96'hC000_0009);
        rd(3'd4, v); chk("R7 dir readback", 96'(v), 96'hFFFF_0000);
    endtask

    task automatic t_fanout();
        @(negedge clk); pad_in = 32'hDEAD_BEEF;
        #1 chk("R8 fanout", periph_in, {3{32'hDEAD_BEEF}});
        @(negedge clk); pad_in = 32'h0123_4567;
        #1 chk("R8 fanout 2", periph_in, {3{32'h0123_4567}});
    endtask

    task automatic t_read_pins();
        logic [31:0] v;
        // pin level changes in the same half-cycle as the read strobe
        @(negedge clk);
        pad_in = 32'h5A5A_1234; bus_rd_en = 1'b1; bus_addr = 3'd0;
        @(negedge clk);
        bus_rd_en = 1'b0; v = bus_rdata;
        chk("R5 read pins", 96'(v), 96'h5A5A_1234);
        pad_in = 32'h0000_0001;
        @(negedge clk);
        chk("R9 rdata hold", 96'(bus_rdata), 96'h5A5A_1234);
        rd(3'd0, v); chk("R5 not latch", 96'(v), 96'h0000_0001);
    endtask

    task automatic t_misc_reads();
        logic [31:0] v;
        rd(3'd1, v); chk("R10 set reads 0", 96'(v), 96'h0);
        rd(3'd2, v); chk("R10 clr reads 0", 96'(v), 96'h0);
        rd(3'd3, v); chk("R10 tgl reads 0", 96'(v), 96'h0);
        rd(3'd7, v); chk("R10 spare reads 0", 96'(v), 96'h0);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_wr_en = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h0000_00FF;
        @(negedge clk);
        bus_rd_en = 1'b0; bus_wr_en = 1'b0;
        chk("R10 read before write", 96'(bus_rdata), 96'hFFFF_0000);
        rd(3'd4, v); chk("R10 write landed", 96'(v), 96'h0000_00FF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_gpio_drive();
        t_bit_ops();
        t_dir_hold();
        t_fsel();
        t_fanout();
        t_read_pins();
        t_misc_reads();
        done = 1;
    end

    initial begin : watchdog
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule